// File: doc/BRIEF.md
# Power Converter Start-Up Sequencer

This block is the phase controller that takes a cascaded-cell rectifier stage, followed by isolated DC-DC converters, from a cold state to full rated operation. It watches a set of settled flags produced by the analog control loops and measurement logic, and it drives the two pre-charge relays, the enables of each control loop, the PWM group enables, the low-duty pre-charge PWM mode select and the reference ramp enables. The loops, the converters and the PWM generators stay outside. They are represented here only by the status flags coming in and the enables going out.

The sequence runs in a fixed order. First the grid phase is tracked. Then the DC-link is charged through a resistor path. The pre-charge is handed over to a bypass relay with a one-cycle make-before-break overlap. Next the output capacitors are charged by switching only the primary bridges at a small duty. After that the cell voltages are balanced while the output is regulated at its pre-charge level. Only then is bulk DC-link regulation enabled, with the DC-link reference ramping to its rating. The output reference ramps last. Each step waits for its flag to stay high for a programmable number of consecutive control ticks. A fault input opens the relays and removes every enable in the same cycle, and the block returns to idle.

Top module: `pwr_startup_seq`

## Requirements
- R1: After reset, `phase` is 0 (idle) and every relay, PWM, loop, ramp and ready output is low.
- R2: In idle, a high `start` with no fault moves `phase` to 1 (grid tracking) on the next clock. `pll_en` is high in phase 1 and in every later phase.
- R3: A phase that waits on a flag advances on the clock edge where `tick` is high and the flag has been high at `tick` for `hold_ticks` consecutive ticks, counting that one. A low flag on any clock restarts the count. A `hold_ticks` of 0 acts as 1.
- R4: Phases run in this order: 1 to 2 on `pll_locked`, 2 to 3 on `link_settled`, 3 to 4 unconditionally after one clock, 4 to 5 on `out_precharged`, 5 to 6 on `cells_balanced`, 6 to 7 on `link_at_rating`, and 7 to 8 on `out_at_rating`. Phase 8 holds until a fault occurs.
- R5: `relay_res` is closed in phases 2 and 3. `relay_byp` is closed from phase 3 on. Both relays are closed together only in phase 3.
- R6: In phase 4, `pre_pwm_mode` and `pri_pwm_en` are high and `sec_pwm_en` is low. `pri_pwm_en` stays high from phase 4 on. `sec_pwm_en` is high from phase 5 on.
- R7: `bal_en` and `vout_reg_en` are high from phase 5 on. `link_reg_en` and `cell_pwm_en` are high only from phase 6 on, so bulk DC-link control never runs without balancing.
- R8: `link_ramp_en` is high from phase 6 on. `out_ramp_en` is high only in phases 7 and 8, which keeps the output at its pre-charge level through phases 5 and 6.
- R9: While `fault` is high, every relay, PWM, loop, ramp and ready output is low in that same cycle, `phase` becomes 0 on the next clock, and `start` is ignored.
- R10: `ready`, which permits load connection, is high only in phase 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin the sequence from idle |
| fault | input | 1 | Protection trip; forces safe outputs and idle |
| tick | input | 1 | Control-period strobe used for flag qualification |
| hold_ticks | input | CNT_W | Consecutive ticks a flag must hold |
| pll_locked | input | 1 | Grid phase tracker locked |
| link_settled | input | 1 | DC-link voltage reached steady state on the resistor path |
| out_precharged | input | 1 | Output capacitors at pre-charge level |
| cells_balanced | input | 1 | Cell DC-link voltages balanced |
| link_at_rating | input | 1 | Total DC-link voltage steady at rating |
| out_at_rating | input | 1 | Output voltage steady at rating |
| phase | output | 4 | Current phase code, 0 to 8 |
| relay_res | output | 1 | Resistor-path pre-charge relay drive |
| relay_byp | output | 1 | Bypass relay drive |
| pll_en | output | 1 | Grid phase tracker enable |
| pre_pwm_mode | output | 1 | Selects the small fixed-duty pre-charge PWM |
| pri_pwm_en | output | 1 | Primary bridge switching enable |
| sec_pwm_en | output | 1 | Secondary bridge switching enable |
| cell_pwm_en | output | 1 | Cascaded-cell bridge switching enable |
| bal_en | output | 1 | Cell balancing loops enable |
| vout_reg_en | output | 1 | Output voltage loop enable |
| link_reg_en | output | 1 | Bulk DC-link voltage loop enable |
| link_ramp_en | output | 1 | DC-link reference ramp enable |
| out_ramp_en | output | 1 | Output reference ramp enable |
| ready | output | 1 | Sequence complete; load may be connected |

## Verification
The sequence is driven through every phase with the flags raised one at a time. This shows that each phase responds only to its own flag and that the enables accumulate in the right order. A run with a four-tick hold, in which a flag drops midway, separates a count that restarts from one that only pauses. A zero hold checks the treat-as-one rule. Faults are injected in the resistor pre-charge phase, in the balancing phase and in the ready phase, with `start` held high during the fault. These runs show that the outputs are cut in the same cycle, separately from the return to idle on the next clock, and that a restart waits until the fault has cleared.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int PH_W = 4;

    typedef enum logic [PH_W-1:0] {
        PH_IDLE      = 4'd0,
        PH_TRACK     = 4'd1,
        PH_LINK_PRE  = 4'd2,
        PH_HANDOVER  = 4'd3,
        PH_OUT_PRE   = 4'd4,
        PH_BALANCE   = 4'd5,
        PH_LINK_RAMP = 4'd6,
        PH_OUT_RAMP  = 4'd7,
        PH_READY     = 4'd8
    } phase_e;

    typedef struct packed {
        logic pll_locked;
        logic link_settled;
        logic out_prechg;
        logic cells_bal;
        logic link_rated;
        logic out_rated;
    } status_t;

    typedef struct packed {
        logic res;
        logic byp;
    } relay_t;

    typedef struct packed {
        logic pre_mode;
        logic pri_en;
        logic sec_en;
        logic cell_en;
    } pwm_t;

    typedef struct packed {
        logic pll_en;
        logic bal_en;
        logic vout_reg_en;
        logic link_reg_en;
        logic link_ramp_en;
        logic out_ramp_en;
        logic ready;
    } loop_t;

    typedef struct packed {
        relay_t rly;
        pwm_t   pwm;
        loop_t  lp;
    } ctrl_t;

    function automatic logic reached(phase_e p, phase_e floor_ph);
        return p >= floor_ph;
    endfunction

    function automatic phase_e step_up(phase_e p);
        return phase_e'(p + 4'd1);
    endfunction

endpackage

// File: rtl/seq_qual.sv
module seq_qual #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             flag,
    input  logic             tick,
    input  logic [CNT_W-1:0] hold,
    output logic             done
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [EXT_W-1:0] need;
    logic [EXT_W-1:0] seen;

    always_comb begin
        need = (hold == '0) ? EXT_W'(1) : {1'b0, hold};
        seen = {1'b0, cnt} + EXT_W'(1);
        done = flag && tick && (seen >= need);
    end

    always_ff @(posedge clk) begin
        if (rst || clr || !flag || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fault,
    input  logic    start,
    input  logic    adv,
    input  status_t stat,
    output phase_e  ph,
    output logic    flag
);
    phase_e ph_nx;

    always_comb begin
        unique case (ph)
            PH_TRACK:     flag = stat.pll_locked;
            PH_LINK_PRE:  flag = stat.link_settled;
            PH_OUT_PRE:   flag = stat.out_prechg;
            PH_BALANCE:   flag = stat.cells_bal;
            PH_LINK_RAMP: flag = stat.link_rated;
            PH_OUT_RAMP:  flag = stat.out_rated;
            default:      flag = 1'b0;
        endcase
    end

    always_comb begin
        ph_nx = ph;
        if (fault) begin
            ph_nx = PH_IDLE;
        end else begin
            unique case (ph)
                PH_IDLE:     if (start) ph_nx = PH_TRACK;
                PH_HANDOVER: ph_nx = PH_OUT_PRE;
                PH_READY:    ph_nx = PH_READY;
                default:     if (adv) ph_nx = step_up(ph);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_IDLE;
        else     ph <= ph_nx;
    end

endmodule

// File: rtl/seq_outdec.sv
module seq_outdec
    import pwr_seq_pkg::*;
(
    input  phase_e ph,
    input  logic   fault,
    output ctrl_t  ctl
);
    ctrl_t raw;

    always_comb begin
        raw.rly.res          = (ph == PH_LINK_PRE) || (ph == PH_HANDOVER);
        raw.rly.byp          = reached(ph, PH_HANDOVER);
        raw.pwm.pre_mode     = (ph == PH_OUT_PRE);
        raw.pwm.pri_en       = reached(ph, PH_OUT_PRE);
        raw.pwm.sec_en       = reached(ph, PH_BALANCE);
        raw.pwm.cell_en      = reached(ph, PH_LINK_RAMP);
        raw.lp.pll_en        = reached(ph, PH_TRACK);
        raw.lp.bal_en        = reached(ph, PH_BALANCE);
        raw.lp.vout_reg_en   = reached(ph, PH_BALANCE);
        raw.lp.link_reg_en   = reached(ph, PH_LINK_RAMP);
        raw.lp.link_ramp_en  = reached(ph, PH_LINK_RAMP);
        raw.lp.out_ramp_en   = reached(ph, PH_OUT_RAMP);
        raw.lp.ready         = (ph == PH_READY);
        ctl = fault ? '0 : raw;
    end

endmodule

// File: rtl/pwr_startup_seq.sv
module pwr_startup_seq
    import pwr_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             fault,
    input  logic             tick,
    input  logic [CNT_W-1:0] hold_ticks,
    input  logic             pll_locked,
    input  logic             link_settled,
    input  logic             out_precharged,
    input  logic             cells_balanced,
    input  logic             link_at_rating,
    input  logic             out_at_rating,
    output logic [PH_W-1:0]  phase,
    output logic             relay_res,
    output logic             relay_byp,
    output logic             pll_en,
    output logic             pre_pwm_mode,
    output logic             pri_pwm_en,
    output logic             sec_pwm_en,
    output logic             cell_pwm_en,
    output logic             bal_en,
    output logic             vout_reg_en,
    output logic             link_reg_en,
    output logic             link_ramp_en,
    output logic             out_ramp_en,
    output logic             ready
);
    status_t stat;
    phase_e  ph;
    logic    flag;
    logic    adv;
    ctrl_t   ctl;

    assign stat = '{pll_locked:   pll_locked,
                    link_settled: link_settled,
                    out_prechg:   out_precharged,
                    cells_bal:    cells_balanced,
                    link_rated:   link_at_rating,
                    out_rated:    out_at_rating};

    seq_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .fault (fault),
        .start (start),
        .adv   (adv),
        .stat  (stat),
        .ph    (ph),
        .flag  (flag)
    );

    seq_qual #(.CNT_W(CNT_W)) u_qual (
        .clk  (clk),
        .rst  (rst),
        .clr  (fault),
        .flag (flag),
        .tick (tick),
        .hold (hold_ticks),
        .done (adv)
    );

    seq_outdec u_dec (
        .ph    (ph),
        .fault (fault),
        .ctl   (ctl)
    );

    assign phase        = ph;
    assign relay_res    = ctl.rly.res;
    assign relay_byp    = ctl.rly.byp;
    assign pre_pwm_mode = ctl.pwm.pre_mode;
    assign pri_pwm_en   = ctl.pwm.pri_en;
    assign sec_pwm_en   = ctl.pwm.sec_en;
    assign cell_pwm_en  = ctl.pwm.cell_en;
    assign pll_en       = ctl.lp.pll_en;
    assign bal_en       = ctl.lp.bal_en;
    assign vout_reg_en  = ctl.lp.vout_reg_en;
    assign link_reg_en  = ctl.lp.link_reg_en;
    assign link_ramp_en = ctl.lp.link_ramp_en;
    assign out_ramp_en  = ctl.lp.out_ramp_en;
    assign ready        = ctl.lp.ready;

endmodule

// File: rtl/pwr_startup_seq_chk.sv
module pwr_startup_seq_chk
    import pwr_seq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            fault,
    input logic [PH_W-1:0] phase,
    input logic            relay_res,
    input logic            relay_byp,
    input logic            pre_pwm_mode,
    input logic            sec_pwm_en,
    input logic            bal_en,
    input logic            vout_reg_en,
    input logic            link_reg_en,
    input logic            out_ramp_en,
    input logic            ready
);
    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && start && !fault) |=> (phase == PH_TRACK));

    p_step_order_r4: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && !fault) |=>
        (phase == $past(phase) || phase == $past(phase) + 4'd1));

    p_overlap_r5: assert property (@(posedge clk) disable iff (rst)
        (relay_res && relay_byp) |-> (phase == PH_HANDOVER));

    p_sec_off_r6: assert property (@(posedge clk) disable iff (rst)
        pre_pwm_mode |-> !sec_pwm_en);

    p_bal_first_r7: assert property (@(posedge clk) disable iff (rst)
        link_reg_en |-> (bal_en && vout_reg_en));

    p_out_ramp_late_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(out_ramp_en) |-> ($past(phase) == PH_LINK_RAMP));

    p_fault_idle_r9: assert property (@(posedge clk) disable iff (rst)
        fault |=> (phase == PH_IDLE));

    p_ready_end_r10: assert property (@(posedge clk) disable iff (rst)
        ready |-> (out_ramp_en && phase == PH_READY));

endmodule

bind pwr_startup_seq pwr_startup_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .fault        (fault),
    .phase        (phase),
    .relay_res    (relay_res),
    .relay_byp    (relay_byp),
    .pre_pwm_mode (pre_pwm_mode),
    .sec_pwm_en   (sec_pwm_en),
    .bal_en       (bal_en),
    .vout_reg_en  (vout_reg_en),
    .link_reg_en  (link_reg_en),
    .out_ramp_en  (out_ramp_en),
    .ready        (ready)
);

// File: tb/sim_pwr_startup_seq.sv
`timescale 1ns/1ps
module sim_pwr_startup_seq;
    localparam int CW = 16;

    logic clk = 0;
    logic rst = 1;
    logic start = 0, fault = 0, tick = 0;
    logic [CW-1:0] hold_ticks = 16'd2;
    logic pll_locked = 0, link_settled = 0, out_precharged = 0;
    logic cells_balanced = 0, link_at_rating = 0, out_at_rating = 0;
    logic [3:0] phase;
    logic relay_res, relay_byp, pll_en, pre_pwm_mode, pri_pwm_en, sec_pwm_en;
    logic cell_pwm_en, bal_en, vout_reg_en, link_reg_en, link_ramp_en;
    logic out_ramp_en, ready;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pwr_startup_seq #(.CNT_W(CW)) u0 (.*);

    // control tick every third clock
    int tdiv = 0;
    always @(posedge clk) begin
        tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
        tick <= (tdiv == 2);
    end

    // behavioural reference model
    int m_ph = 0;
    int m_cnt = 0;

    function automatic bit m_flag(int p);
        case (p)
            1: return pll_locked;
            2: return link_settled;
            4: return out_precharged;
            5: return cells_balanced;
            6: return link_at_rating;
            7: return out_at_rating;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        int need;
        need = (hold_ticks == 0) ? 1 : int'(hold_ticks);
        if (rst || fault) begin
            m_ph <= 0; m_cnt <= 0;
        end else if (m_ph == 0) begin
            m_cnt <= 0;
            if (start) m_ph <= 1;
        end else if (m_ph == 3) begin
            m_cnt <= 0; m_ph <= 4;
        end else if (m_ph == 8) begin
            m_cnt <= 0;
        end else if (!m_flag(m_ph)) begin
            m_cnt <= 0;
        end else if (tick) begin
            if (m_cnt + 1 >= need) begin m_ph <= m_ph + 1; m_cnt <= 0; end
            else m_cnt <= m_cnt + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (!finished) begin
            bit g;
            int p;
            g = !fault;
            p = m_ph;
            chk("R4 phase", phase, p);
            chk("R5 relay_res", relay_res, g && (p == 2 || p == 3));
            chk("R5 relay_byp", relay_byp, g && p >= 3);
            chk("R2 pll_en", pll_en, g && p >= 1);
            chk("R6 pre_pwm_mode", pre_pwm_mode, g && p == 4);
            chk("R6 pri_pwm_en", pri_pwm_en, g && p >= 4);
            chk("R6 sec_pwm_en", sec_pwm_en, g && p >= 5);
            chk("R7 cell_pwm_en", cell_pwm_en, g && p >= 6);
            chk("R7 bal_en", bal_en, g && p >= 5);
            chk("R7 vout_reg_en", vout_reg_en, g && p >= 5);
            chk("R7 link_reg_en", link_reg_en, g && p >= 6);
            chk("R8 link_ramp_en", link_ramp_en, g && p >= 6);
            chk("R8 out_ramp_en", out_ramp_en, g && p >= 7);
            chk("R10 ready", ready, g && p == 8);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_phase(input int target, input string tag);
        for (int i = 0; i < 400; i++) begin
            if (phase == target) break;
            step(1);
        end
        chk(tag, phase, target);
    endtask

    task automatic clear_flags();
        pll_locked = 0; link_settled = 0; out_precharged = 0;
        cells_balanced = 0; link_at_rating = 0; out_at_rating = 0;
    endtask

    task automatic report();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired phase=%0d expected=done", phase);
        report();
    end

    initial begin
        step(5);
        // R1: reset state
        chk("R1 reset phase", phase, 0);
        chk("R1 reset outputs", {relay_res, relay_byp, pll_en, pri_pwm_en, ready}, 0);
        rst = 0;
        step(3);
        chk("R1 idle without start", phase, 0);

        // R2: start
        start = 1; step(1); start = 0;
        chk("R2 start to tracking", phase, 1);
        chk("R2 pll_en", pll_en, 1);

        // R4 full sequence, one flag at a time
        link_settled = 1; step(20);
        chk("R4 wrong flag ignored", phase, 1);
        link_settled = 0;
        pll_locked = 1;     wait_phase(2, "R4 to resistor pre-charge");
        chk("R5 resistor relay only", {relay_res, relay_byp}, 2'b10);
        link_settled = 1;   wait_phase(3, "R4 to handover");
        chk("R5 both relays closed", {relay_res, relay_byp}, 2'b11);
        step(1);
        chk("R4 handover one clock", phase, 4);
        chk("R6 primary only", {pre_pwm_mode, pri_pwm_en, sec_pwm_en}, 3'b110);
        out_precharged = 1; wait_phase(5, "R4 to balance");
        chk("R8 output held at pre-charge", out_ramp_en, 0);
        chk("R7 bulk link off in balance", link_reg_en, 0);
        cells_balanced = 1; wait_phase(6, "R4 to link ramp");
        link_at_rating = 1; wait_phase(7, "R4 to output ramp");
        out_at_rating = 1;  wait_phase(8, "R4 to ready");
        chk("R10 ready", ready, 1);
        step(30);
        chk("R4 ready holds", phase, 8);

        // R9: fault from ready, start held high
        start = 1; fault = 1;
        step(1);
        chk("R9 outputs cut", {relay_byp, pri_pwm_en, ready}, 0);
        step(10);
        chk("R9 start ignored in fault", phase, 0);
        fault = 0; start = 0; clear_flags();
        step(2);
        chk("R9 stays idle after fault", phase, 0);

        // R3: hold of four ticks, flag dropped midway
        hold_ticks = 16'd4;
        start = 1; step(1); start = 0;
        pll_locked = 1; step(7);
        pll_locked = 0; step(15);
        chk("R3 count restarts on drop", phase, 1);
        pll_locked = 1; step(9);
        chk("R3 not yet qualified", phase, 1);
        wait_phase(2, "R3 qualified after hold");

        // R3: zero hold acts as one
        hold_ticks = 16'd0;
        link_settled = 1; step(4);
        chk("R3 zero hold advances", phase >= 3, 1);
        wait_phase(4, "R4 reached output pre-charge");

        // R9: fault in balance
        out_precharged = 1; wait_phase(5, "R4 balance again");
        fault = 1; #0;
        @(negedge clk);
        chk("R9 same-cycle cut", {bal_en, sec_pwm_en, relay_byp}, 0);
        step(1); fault = 0; clear_flags();
        step(1);
        chk("R9 idle after fault", phase, 0);

        // R9: fault with resistor relay closed
        hold_ticks = 16'd1;
        start = 1; step(1); start = 0;
        pll_locked = 1; wait_phase(2, "R4 resistor phase again");
        fault = 1;
        @(negedge clk);
        chk("R9 resistor relay opens", relay_res, 0);
        step(1); fault = 0;
        step(1);
        chk("R9 back to idle", phase, 0);

        step(5);
        report();
    end
endmodule